// File: doc/BRIEF.md
# Four-Channel Compare-Match PWM Timer

This unit holds four independent 16-bit timer channels behind one 16-bit register port. Each channel counts ticks of a prescaled clock, compares its counter against four general compare registers, and drives one output pin. A selectable compare register can clear the counter. This makes one register the period and another the duty point.

The pin of each channel starts from a programmed initial level. A match with compare register A applies a programmed action: keep, drive low, drive high or toggle. In PWM mode, the match that clears the counter also returns the pin to its initial level. While a channel is halted, software can force the pin to a fixed level by rewriting the I/O control register, which covers 0% and 100% duty. A shared start register holds one run bit per channel.

The register port is a plain control port, not a stream. A write takes effect at the clock edge on which `bus_we` is high, so there is no back-pressure. Read data is a combinational function of `bus_addr`.

Top module: `pwm_timer_unit`

## Requirements
- R1: After reset every register and counter reads zero, every channel is halted and every pin is low.
- R2: The start register is at byte address 0x00, and bit n runs channel n. While bit n is 0, channel n does not count and keeps its count. Bits above the channel count read as zero.
- R3: Control register bits [1:0] divide the clock by 1, 4, 16 or 64 (codes 0 to 3). A shared 6-bit phase counter resets to 0 and increments on every clock. For a divide N greater than 1, a rising tick occurs in a cycle where phase mod N equals N/2-1, and a falling tick where phase mod N equals N-1. Control bits [4:3] select the counting edge: 0 rising, 1 falling, 2 or 3 both. With divide 1, every cycle is a tick.
- R4: On each tick of a running channel the counter adds one, and it wraps from 0xFFFF to 0.
- R5: Control bits [7:5] select the clear source. Code 1 selects A, 2 selects B, 5 selects C and 6 selects D; any other code never clears. On a tick where the counter equals the selected register, the counter becomes 0 instead of incrementing.
- R6: I/O control bit 2 is the initial pin level. On a tick where the counter equals register A, I/O control bits [1:0] act on the pin: 0 keep, 1 low, 2 high, 3 toggle. Every mode code other than 2 behaves as normal mode.
- R7: In PWM mode (mode bits [1:0] = 2), a tick that clears the counter also sets the pin to the initial level, overriding the A action.
- R8: A write to the I/O control register of a halted channel sets the pin to the written bit 2 at that edge. The same write to a running channel does not change the pin by itself.
- R9: Channel n registers sit at 0x10 + n*0x40 plus these offsets: control 0x00, mode 0x04, I/O control 0x08, counter 0x14, A/B/C/D 0x18/0x1C/0x20/0x24. Reads return the stored 16-bit values, including the ignored mode bits 4 to 6, and the live counter. Every other address reads zero and ignores writes.
- R10: A write to register A while a channel runs is used from the next comparison on.
- R11: A bus write to the counter overrides that cycle's count or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| pwm_out | output | 4 | One output pin per channel |

## Verification
The bench targets these corner cases:
- Counter wrap at 0xFFFF: a design that saturated there would freeze the counter.
- Clear sources on A and C, and divides of 4, 16 and 64 with falling and both-edge counting: an off-by-one phase decode would shift every pin transition by a cycle.
- Duty change in mid-period and the PWM restore at the clear match: a design that let the A action win would leave the pin stuck at the active level.
- Pin forcing on a halted channel, and a running channel that ignores the same write directly: a design that got this wrong would glitch live waveforms.
- Unmapped addresses, including the interrupt-enable and status slots: a design that stored them would read back non-zero values.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int REG_W = 16;
  localparam int NCMP  = 4;

  localparam logic [5:0] OFS_CTL  = 6'h00;
  localparam logic [5:0] OFS_MODE = 6'h04;
  localparam logic [5:0] OFS_IOC  = 6'h08;
  localparam logic [5:0] OFS_CNT  = 6'h14;
  localparam logic [5:0] OFS_CMP0 = 6'h18;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_FLIP = 2'd3
  } match_act_e;

  // one-hot select of the compare register that clears the counter
  function automatic logic [NCMP-1:0] clear_select(input logic [2:0] code);
    case (code)
      3'd1:    return 4'b0001;
      3'd2:    return 4'b0010;
      3'd5:    return 4'b0100;
      3'd6:    return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  // count-enable pulse derived from the shared phase counter
  function automatic logic phase_tick(input logic [5:0] phase,
                                      input logic [1:0] psc,
                                      input logic [1:0] edge_code);
    logic [6:0] span;
    logic [5:0] mask;
    logic [5:0] half;
    logic [5:0] p;
    logic       rise;
    logic       fall;
    span = 7'd1 << {psc, 1'b0};
    mask = 6'((span - 7'd1));
    half = 6'((span >> 1));
    p    = phase & mask;
    rise = (p == half - 6'd1);
    fall = (p == mask);
    if (psc == 2'd0) return 1'b1;
    if (edge_code[1]) return rise | fall;
    if (edge_code[0]) return fall;
    return rise;
  endfunction
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_timer_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0][1:0] psc_sel,
  input  logic [NCH-1:0][1:0] edge_sel,
  output logic [NCH-1:0]      tick
);
  localparam int PHASE_W = 6;

  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_q + 1'b1;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_tick
    assign tick[c] = phase_tick(phase_q, psc_sel[c], edge_sel[c]);
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_timer_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  input  logic                       tick,
  input  logic                       wr_ctl,
  input  logic                       wr_mode,
  input  logic                       wr_ioc,
  input  logic                       wr_cnt,
  input  logic [NCMP-1:0]            wr_cmp,
  input  logic [REG_W-1:0]           wdata,
  output logic [REG_W-1:0]           ctl_q,
  output logic [REG_W-1:0]           mode_q,
  output logic [REG_W-1:0]           ioc_q,
  output logic [REG_W-1:0]           cnt_q,
  output logic [NCMP-1:0][REG_W-1:0] cmp_q,
  output logic                       pin
);
  logic [NCMP-1:0] hit;
  logic            clr_hit;
  logic            pwm_mode;
  logic            count_en;
  logic            pin_nxt;
  logic [REG_W-1:0] cnt_nxt;
  match_act_e      act;

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    assign hit[k] = (cnt_q == cmp_q[k]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cmp_q[k] <= '0;
      else if (wr_cmp[k]) cmp_q[k] <= wdata;
    end
  end

  assign clr_hit  = |(hit & clear_select(ctl_q[7:5]));
  assign pwm_mode = (mode_q[1:0] == 2'd2);
  assign count_en = run & tick;
  assign act      = match_act_e'(ioc_q[1:0]);

  always_comb begin
    pin_nxt = pin;
    if (count_en) begin
      if (hit[0]) begin
        case (act)
          ACT_LOW:  pin_nxt = 1'b0;
          ACT_HIGH: pin_nxt = 1'b1;
          ACT_FLIP: pin_nxt = ~pin;
          default:  pin_nxt = pin;
        endcase
      end
      if (pwm_mode && clr_hit) pin_nxt = ioc_q[2];
    end else if (!run && wr_ioc) begin
      pin_nxt = wdata[2];
    end
  end

  always_comb begin
    cnt_nxt = cnt_q;
    if (wr_cnt)        cnt_nxt = wdata;
    else if (count_en) cnt_nxt = clr_hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      mode_q <= '0;
      ioc_q  <= '0;
      cnt_q  <= '0;
      pin    <= 1'b0;
    end else begin
      if (wr_ctl)  ctl_q  <= wdata;
      if (wr_mode) mode_q <= wdata;
      if (wr_ioc)  ioc_q  <= wdata;
      cnt_q <= cnt_nxt;
      pin   <= pin_nxt;
    end
  end

  assert_hold_halted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt_q));
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !wr_cnt && !clr_hit && cnt_q == 16'hFFFF) |=> (cnt_q == 16'h0000));
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !wr_cnt && clr_hit) |=> (cnt_q == 16'h0000));
  assert_pwm_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && pwm_mode && clr_hit) |=> (pin == $past(ioc_q[2])));
  assert_force_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && wr_ioc) |=> (pin == $past(wdata[2])));
  assert_cnt_override_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(wdata)));
endmodule

// File: rtl/pwm_timer_unit.sv
module pwm_timer_unit
  import pwm_timer_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int CH_BASE   = 16,
  parameter int CH_STRIDE = 64,
  parameter int ADDR_W    = $clog2(CH_BASE + NCH * CH_STRIDE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int OFS_W    = $clog2(CH_STRIDE);
  localparam int CH_IDX_W = ADDR_W - OFS_W;

  logic [NCH-1:0]      start_q;
  logic [ADDR_W-1:0]   rel_addr;
  logic                in_ch_space;
  logic [CH_IDX_W-1:0] ch_idx;
  logic [OFS_W-1:0]    reg_ofs;
  logic                start_hit;
  logic [NCH-1:0]      tick;
  logic [NCH-1:0][1:0] psc_sel;
  logic [NCH-1:0][1:0] edge_sel;

  logic [REG_W-1:0]           ctl_a  [NCH];
  logic [REG_W-1:0]           mode_a [NCH];
  logic [REG_W-1:0]           ioc_a  [NCH];
  logic [REG_W-1:0]           cnt_a  [NCH];
  logic [NCMP-1:0][REG_W-1:0] cmp_a  [NCH];

  assign rel_addr    = bus_addr - ADDR_W'(CH_BASE);
  assign in_ch_space = (bus_addr >= ADDR_W'(CH_BASE));
  assign ch_idx      = rel_addr[ADDR_W-1:OFS_W];
  assign reg_ofs     = rel_addr[OFS_W-1:0];
  assign start_hit   = (bus_addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   start_q <= '0;
    else if (bus_we && start_hit) start_q <= bus_wdata[NCH-1:0];
  end

  pwm_tick_gen #(.NCH(NCH)) u_ticks (
    .clk      (clk),
    .rst_n    (rst_n),
    .psc_sel  (psc_sel),
    .edge_sel (edge_sel),
    .tick     (tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic            sel;
    logic [NCMP-1:0] wr_cmp;
    assign sel = in_ch_space && (ch_idx == CH_IDX_W'(c)) && bus_we;
    for (genvar k = 0; k < NCMP; k++) begin : g_wcmp
      assign wr_cmp[k] = sel && (reg_ofs == OFS_CMP0 + 6'(4 * k));
    end
    assign psc_sel[c]  = ctl_a[c][1:0];
    assign edge_sel[c] = ctl_a[c][4:3];

    pwm_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (start_q[c]),
      .tick    (tick[c]),
      .wr_ctl  (sel && reg_ofs == OFS_CTL),
      .wr_mode (sel && reg_ofs == OFS_MODE),
      .wr_ioc  (sel && reg_ofs == OFS_IOC),
      .wr_cnt  (sel && reg_ofs == OFS_CNT),
      .wr_cmp  (wr_cmp),
      .wdata   (bus_wdata),
      .ctl_q   (ctl_a[c]),
      .mode_q  (mode_a[c]),
      .ioc_q   (ioc_a[c]),
      .cnt_q   (cnt_a[c]),
      .cmp_q   (cmp_a[c]),
      .pin     (pwm_out[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (start_hit) begin
      bus_rdata = REG_W'(start_q);
    end else if (in_ch_space) begin
      for (int c = 0; c < NCH; c++) begin
        if (ch_idx == CH_IDX_W'(c)) begin
          case (reg_ofs)
            OFS_CTL:  bus_rdata = ctl_a[c];
            OFS_MODE: bus_rdata = mode_a[c];
            OFS_IOC:  bus_rdata = ioc_a[c];
            OFS_CNT:  bus_rdata = cnt_a[c];
            6'h18:    bus_rdata = cmp_a[c][0];
            6'h1C:    bus_rdata = cmp_a[c][1];
            6'h20:    bus_rdata = cmp_a[c][2];
            6'h24:    bus_rdata = cmp_a[c][3];
            default:  bus_rdata = '0;
          endcase
        end
      end
    end
  end

  assert_reset_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pwm_out == '0));
  assert_halted_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q == '0 && !bus_we) |=> $stable(pwm_out));
endmodule

// File: tb/pwm_timer_unit_test.sv
module pwm_timer_unit_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  always #(CLK_P/2) clk = ~clk;

  pwm_timer_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  // behavioural reference state
  int m_ctl[4], m_mode[4], m_ioc[4], m_cnt[4], m_pin[4];
  int m_cmp[4][4];
  int m_start, m_phase;

  function automatic int caddr(int ch, int ofs);
    return 16 + ch * 64 + ofs;
  endfunction

  function automatic int model_read(int a);
    int off, ch, r;
    if (a == 0) return m_start;
    if (a < 16) return 0;
    off = a - 16; ch = off / 64; r = off % 64;
    if (ch > 3) return 0;
    case (r)
      'h00: return m_ctl[ch];
      'h04: return m_mode[ch];
      'h08: return m_ioc[ch];
      'h14: return m_cnt[ch];
      'h18: return m_cmp[ch][0];
      'h1C: return m_cmp[ch][1];
      'h20: return m_cmp[ch][2];
      'h24: return m_cmp[ch][3];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_ctl[c] = 0; m_mode[c] = 0; m_ioc[c] = 0; m_cnt[c] = 0; m_pin[c] = 0;
        for (int k = 0; k < 4; k++) m_cmp[c][k] = 0;
      end
      m_start = 0; m_phase = 0;
    end else begin
      int np[4], nc[4];
      for (int c = 0; c < 4; c++) begin
        int n, p, ec, ci;
        bit t, rise, fall, running;
        running = m_start[c];
        n = 1 << (2 * (m_ctl[c] & 3));
        p = m_phase % n;
        ec = (m_ctl[c] >> 3) & 3;
        rise = (p == n / 2 - 1);
        fall = (p == n - 1);
        if (n == 1) t = 1;
        else if (ec >= 2) t = rise || fall;
        else if (ec == 1) t = fall;
        else t = rise;
        case ((m_ctl[c] >> 5) & 7)
          1: ci = 0; 2: ci = 1; 5: ci = 2; 6: ci = 3;
          default: ci = -1;
        endcase
        np[c] = m_pin[c]; nc[c] = m_cnt[c];
        if (running && t) begin
          if (m_cnt[c] == m_cmp[c][0]) begin
            case (m_ioc[c] & 3)
              1: np[c] = 0;
              2: np[c] = 1;
              3: np[c] = 1 - m_pin[c];
              default: ;
            endcase
          end
          if (ci >= 0 && m_cnt[c] == m_cmp[c][ci]) begin
            nc[c] = 0;
            if ((m_mode[c] & 3) == 2) np[c] = (m_ioc[c] >> 2) & 1;
          end else begin
            nc[c] = (m_cnt[c] + 1) & 'hFFFF;
          end
        end
      end
      if (bus_we) begin
        int a, off, ch, r, d;
        a = int'(bus_addr); d = int'(bus_wdata);
        if (a == 0) m_start = d & 'hF;
        else if (a >= 16) begin
          off = a - 16; ch = off / 64; r = off % 64;
          if (ch < 4) begin
            case (r)
              'h00: m_ctl[ch] = d;
              'h04: m_mode[ch] = d;
              'h08: begin
                m_ioc[ch] = d;
                if (!m_start[ch]) np[ch] = (d >> 2) & 1;
              end
              'h14: nc[ch] = d;
              'h18: m_cmp[ch][0] = d;
              'h1C: m_cmp[ch][1] = d;
              'h20: m_cmp[ch][2] = d;
              'h24: m_cmp[ch][3] = d;
              default: ;
            endcase
          end
        end
      end
      for (int c = 0; c < 4; c++) begin
        m_pin[c] = np[c]; m_cnt[c] = nc[c];
      end
      m_phase = (m_phase + 1) % 64;
    end
  end

  // pin comparison every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      for (int c = 0; c < 4; c++) begin
        checks++;
        if (int'(pwm_out[c]) != m_pin[c]) begin
          errors++;
          $display("FAIL %s pin ch%0d: actual %0d expected %0d", cur_req, c, pwm_out[c], m_pin[c]);
        end
      end
    end
  end

  task automatic wr(int a, int d);
    bus_we = 1'b1; bus_addr = 9'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(int a, string req);
    int exp;
    bus_addr = 9'(a);
    #1;
    exp = model_read(a);
    checks++;
    if (int'(bus_rdata) != exp) begin
      errors++;
      $display("FAIL %s read 0x%0h: actual 0x%0h expected 0x%0h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1;
    // R1: reset values
    cur_req = "R1";
    rd_chk(0, "R1");
    rd_chk(caddr(0, 'h00), "R1");
    rd_chk(caddr(2, 'h14), "R1");
    rd_chk(caddr(3, 'h24), "R1");

    // R7: channel 0 PWM, clear on B, init high, low at A
    cur_req = "R7";
    wr(caddr(0, 'h00), 'h40);
    wr(caddr(0, 'h04), 'h2);
    wr(caddr(0, 'h08), 'h5);
    wr(caddr(0, 'h18), 3);
    wr(caddr(0, 'h1C), 9);
    rd_chk(caddr(0, 'h1C), "R9");
    wr(0, 1);
    idle(40);
    rd_chk(caddr(0, 'h14), "R4");
    // R10: duty change mid-period
    cur_req = "R10";
    wr(caddr(0, 'h18), 6);
    idle(40);

    // R6/R5: channel 1 normal mode, toggle on A, clear on A, div 4 falling
    cur_req = "R6";
    wr(caddr(1, 'h00), 'h29);
    wr(caddr(1, 'h08), 'h3);
    wr(caddr(1, 'h18), 5);
    wr(0, 3);
    idle(150);
    rd_chk(caddr(1, 'h14), "R5");

    // R3: channel 2 div 16 both edges, PWM, clear on C, init low, high at A
    cur_req = "R3";
    wr(caddr(2, 'h00), 'hB2);
    wr(caddr(2, 'h04), 'h72);
    rd_chk(caddr(2, 'h04), "R9");
    wr(caddr(2, 'h08), 'h2);
    wr(caddr(2, 'h18), 2);
    wr(caddr(2, 'h20), 4);
    wr(0, 7);
    idle(300);
    rd_chk(caddr(2, 'h14), "R3");

    // R4: channel 3 wrap at 0xFFFF, no clear source, toggle at A=0
    cur_req = "R4";
    wr(caddr(3, 'h00), 'h0);
    wr(caddr(3, 'h08), 'h3);
    wr(caddr(3, 'h14), 'hFFF0);
    wr(0, 'hF);
    idle(30);
    rd_chk(caddr(3, 'h14), "R4");
    // R11: counter write on a running channel
    cur_req = "R11";
    wr(caddr(3, 'h14), 'h1234);
    rd_chk(caddr(3, 'h14), "R11");
    // R3: div 64 rising on channel 3
    cur_req = "R3";
    wr(caddr(3, 'h00), 'h03);
    idle(400);
    rd_chk(caddr(3, 'h14), "R3");

    // R8: running channel ignores a direct pin force
    cur_req = "R8";
    wr(caddr(1, 'h08), 'h7);
    idle(20);
    // R2: halt channel 0 and keep its count
    cur_req = "R2";
    wr(0, 'hE);
    rd_chk(caddr(0, 'h14), "R2");
    idle(25);
    rd_chk(caddr(0, 'h14), "R2");
    cur_req = "R8";
    wr(caddr(0, 'h08), 'h4);
    idle(5);
    wr(caddr(0, 'h08), 'h0);
    idle(5);

    // R9: unmapped addresses and start-register width
    cur_req = "R9";
    wr(caddr(0, 'h0C), 'hBEEF);
    rd_chk(caddr(0, 'h0C), "R9");
    wr(caddr(1, 'h10), 'h1111);
    rd_chk(caddr(1, 'h10), "R9");
    wr(2, 'hFFFF);
    rd_chk(2, "R9");
    wr(caddr(3, 'h30), 'h5555);
    rd_chk(caddr(3, 'h30), "R9");
    wr(0, 'hFFF0);
    rd_chk(0, "R2");
    idle(10);
    rd_chk(caddr(1, 'h14), "R2");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule